// File: doc/BRIEF.md
# Trapping Integer Adder-Subtractor

This block adds or subtracts two 32-bit two's-complement operands in a single combinational pass and decides, in the same cycle, whether the operation may write its result back. Subtraction reuses the adder by feeding it the inverted second operand with a carry-in of one. The add-immediate forms take a 16-bit immediate and sign-extend it before the sum.

Each operation comes in two flavours. The checked flavour raises a precise trap on signed overflow. It suppresses writeback, redirects the next fetch to a fixed handler address, and on the following clock edge stores the faulting instruction's PC in an exception PC register. The wrapping flavour never traps and always writes the modulo result. The saved PC stays visible on a dedicated output, so that handler code can read it and return after corrective action.

Top module: `addsub_trap_unit`

## Requirements
- R1: For the add opcodes (checked add = 3'd0, wrapping add = 3'd3), `sum_out` equals `opnd_a + opnd_b` modulo 2^32.
- R2: For the subtract opcodes (checked sub = 3'd2, wrapping sub = 3'd5), `sum_out` equals `opnd_a - opnd_b` modulo 2^32, computed as `opnd_a + ~opnd_b + 1`.
- R3: For the immediate opcodes (checked = 3'd1, wrapping = 3'd4), `imm16` is sign-extended from bit 15, and `sum_out` equals `opnd_a` plus that value modulo 2^32.
- R4: An addition overflows exactly when both addends have the same sign bit and the sum's sign bit differs from it. Addends of opposite sign never overflow.
- R5: A subtraction overflows exactly when the operands differ in sign and the result's sign differs from `opnd_a`. Operands of the same sign never overflow.
- R6: The wrapping opcodes (3'd3, 3'd4, 3'd5) never raise `redirect`. When `op_valid` is high they always raise `wr_en`.
- R7: A checked opcode that overflows while `op_valid` is high drives `wr_en` low, `redirect` high and `fetch_target` equal to the `HANDLER_ADDR` parameter (default 32'h8000_0180), all in the same cycle.
- R8: Without a trap, `redirect` is low and `fetch_target` equals `cur_pc + 4`.
- R9: `saved_pc` takes the value of `cur_pc` on the clock edge that ends a trapping cycle, and holds its value on every other edge.
- R10: While `rst_n` is low, `saved_pc` reads zero.
- R11: With `op_valid` low, `wr_en` and `redirect` are low and `saved_pc` is unchanged, even for overflowing operands.
- R12: Opcodes 3'd6 and 3'd7 are unused. They never raise `wr_en` or `redirect`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is present this cycle |
| op_code | input | 3 | Operation class (see R1 to R3, R12) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand (register forms) |
| imm16 | input | 16 | Immediate (immediate forms) |
| cur_pc | input | 32 | Address of the current instruction |
| sum_out | output | 32 | Wrapped result |
| wr_en | output | 1 | Result may be written back |
| redirect | output | 1 | Fetch must go to `fetch_target` due to a trap |
| fetch_target | output | 32 | Next fetch address |
| saved_pc | output | 32 | Exception PC register contents |

## Verification
On every cycle, assertions check that a trap and a writeback are never both active, and that a redirect always points at the handler. They also check that wrapping and idle operations never trap, and that the saved PC either loads the faulting PC after a trap or stays stable otherwise. The correctness of the sum itself, and the sign-based overflow rules at the exact boundary values, can only be shown by the bench's vectors. The same holds for the sign extension of the immediate and the reset value of the saved PC.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD_CHK  = 3'd0,
    OP_ADDI_CHK = 3'd1,
    OP_SUB_CHK  = 3'd2,
    OP_ADD_WRP  = 3'd3,
    OP_ADDI_WRP = 3'd4,
    OP_SUB_WRP  = 3'd5,
    OP_RSV6     = 3'd6,
    OP_RSV7     = 3'd7
  } op_e;

  typedef struct packed {
    logic legal;
    logic checked;
    logic is_sub;
    logic use_imm;
  } op_dec_t;

  function automatic op_dec_t decode_op(input op_e op);
    op_dec_t d;
    d = '0;
    unique case (op)
      OP_ADD_CHK:  d = '{legal: 1'b1, checked: 1'b1, is_sub: 1'b0, use_imm: 1'b0};
      OP_ADDI_CHK: d = '{legal: 1'b1, checked: 1'b1, is_sub: 1'b0, use_imm: 1'b1};
      OP_SUB_CHK:  d = '{legal: 1'b1, checked: 1'b1, is_sub: 1'b1, use_imm: 1'b0};
      OP_ADD_WRP:  d = '{legal: 1'b1, checked: 1'b0, is_sub: 1'b0, use_imm: 1'b0};
      OP_ADDI_WRP: d = '{legal: 1'b1, checked: 1'b0, is_sub: 1'b0, use_imm: 1'b1};
      OP_SUB_WRP:  d = '{legal: 1'b1, checked: 1'b0, is_sub: 1'b1, use_imm: 1'b0};
      default:     d = '0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/addsub_rst_sync.sv
module addsub_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/addsub_datapath.sv
module addsub_datapath
  import addsub_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_code,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [IMM_W-1:0]  imm16,
  output logic [DATA_W-1:0] sum,
  output logic              ovf,
  output logic              legal,
  output logic              checked
);
  localparam int MSB = DATA_W - 1;
  localparam int EXT_W = DATA_W - IMM_W;

  op_dec_t           dec;
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] b_sel;
  logic [DATA_W-1:0] b_add;
  logic [DATA_W-1:0] cin;

  always_comb begin
    dec     = decode_op(op_e'(op_code));
    imm_ext = {{EXT_W{imm16[IMM_W-1]}}, imm16};
    b_sel   = dec.use_imm ? imm_ext : opnd_b;
    b_add   = dec.is_sub ? ~b_sel : b_sel;
    cin     = {{(DATA_W-1){1'b0}}, dec.is_sub};
    sum     = opnd_a + b_add + cin;
    // same-sign addends whose sum flips sign
    ovf     = (opnd_a[MSB] == b_add[MSB]) && (sum[MSB] != opnd_a[MSB]);
    legal   = dec.legal;
    checked = dec.checked;
  end

  // opposite-sign addends can never overflow
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec.is_sub && (opnd_a[MSB] != b_sel[MSB])) |-> !ovf);
  // same-sign subtraction can never overflow
  assert_sub_same_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.is_sub && (opnd_a[MSB] == b_sel[MSB])) |-> !ovf);
endmodule

// File: rtl/addsub_trap_ctl.sv
module addsub_trap_ctl #(
  parameter int              DATA_W       = 32,
  parameter logic [DATA_W-1:0] HANDLER_ADDR = 32'h8000_0180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              legal,
  input  logic              checked,
  input  logic              ovf,
  input  logic [DATA_W-1:0] cur_pc,
  output logic              wr_en,
  output logic              redirect,
  output logic [DATA_W-1:0] fetch_target,
  output logic [DATA_W-1:0] saved_pc
);
  localparam logic [DATA_W-1:0] PC_STEP = DATA_W'(4);

  logic              trap;
  logic              epc_en;
  logic [DATA_W-1:0] epc_d;
  logic [DATA_W-1:0] epc_q;

  always_comb begin
    trap         = op_valid && legal && checked && ovf;
    wr_en        = op_valid && legal && !trap;
    redirect     = trap;
    fetch_target = trap ? HANDLER_ADDR : (cur_pc + PC_STEP);
    epc_en       = trap;
    epc_d        = epc_en ? cur_pc : epc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) epc_q <= '0;
    else        epc_q <= epc_d;
  end

  assign saved_pc = epc_q;

  assert_trap_no_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> !wr_en);
  assert_handler_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (fetch_target == HANDLER_ADDR));
  assert_epc_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (saved_pc == $past(cur_pc)));
  assert_epc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |=> $stable(saved_pc));
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> (!wr_en && !redirect));
endmodule

// File: rtl/addsub_trap_unit.sv
module addsub_trap_unit
  import addsub_pkg::*;
#(
  parameter int                DATA_W       = 32,
  parameter int                IMM_W        = 16,
  parameter logic [DATA_W-1:0] HANDLER_ADDR = 32'h8000_0180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [DATA_W-1:0] cur_pc,
  output logic [DATA_W-1:0] sum_out,
  output logic              wr_en,
  output logic              redirect,
  output logic [DATA_W-1:0] fetch_target,
  output logic [DATA_W-1:0] saved_pc
);
  logic rst_n_sync;
  logic ovf;
  logic legal;
  logic checked;

  addsub_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  addsub_datapath #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .op_code (op_code),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .imm16   (imm16),
    .sum     (sum_out),
    .ovf     (ovf),
    .legal   (legal),
    .checked (checked)
  );

  addsub_trap_ctl #(.DATA_W(DATA_W), .HANDLER_ADDR(HANDLER_ADDR)) u_trap (
    .clk          (clk),
    .rst_n        (rst_n_sync),
    .op_valid     (op_valid),
    .legal        (legal),
    .checked      (checked),
    .ovf          (ovf),
    .cur_pc       (cur_pc),
    .wr_en        (wr_en),
    .redirect     (redirect),
    .fetch_target (fetch_target),
    .saved_pc     (saved_pc)
  );

  assert_wrap_never_traps_R6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (op_valid && (op_code inside {3'd3, 3'd4, 3'd5})) |-> (!redirect && wr_en));
  assert_unused_op_R12: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (op_code inside {3'd6, 3'd7}) |-> (!redirect && !wr_en));
endmodule

// File: tb/tb_addsub_trap_unit.sv
`timescale 1ns/1ps
module tb_addsub_trap_unit;
  localparam logic [31:0] HANDLER = 32'h8000_0180;
  localparam int NV = 14;

  // {op, a, b, imm, expected sum, expected trap}
  localparam logic [115:0] VEC [NV] = '{
    {3'd0, 32'h0000_0005, 32'h0000_0007, 16'h0000, 32'h0000_000C, 1'b0}, // R1
    {3'd0, 32'h7FFF_FFFF, 32'h0000_0001, 16'h0000, 32'h8000_0000, 1'b1}, // R4 pos+pos
    {3'd0, 32'h8000_0000, 32'h8000_0000, 16'h0000, 32'h0000_0000, 1'b1}, // R4 neg+neg
    {3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 32'h0000_0000, 1'b0}, // R4 mixed
    {3'd2, 32'h0000_0007, 32'h0000_0006, 16'h0000, 32'h0000_0001, 1'b0}, // R2
    {3'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0000, 32'h8000_0000, 1'b1}, // R5 pos-neg
    {3'd2, 32'h8000_0000, 32'h0000_0001, 16'h0000, 32'h7FFF_FFFF, 1'b1}, // R5 neg-pos
    {3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0000, 32'h0000_0000, 1'b0}, // R5 same sign
    {3'd1, 32'h0000_000A, 32'hDEAD_BEEF, 16'hFFFF, 32'h0000_0009, 1'b0}, // R3
    {3'd1, 32'h7FFF_FFF0, 32'h0000_0000, 16'h0010, 32'h8000_0000, 1'b1}, // R3 ovf
    {3'd1, 32'h0000_0005, 32'h0000_0000, 16'h8000, 32'hFFFF_8005, 1'b0}, // R3 sext
    {3'd3, 32'h7FFF_FFFF, 32'h0000_0001, 16'h0000, 32'h8000_0000, 1'b0}, // R6
    {3'd5, 32'h8000_0000, 32'h0000_0001, 16'h0000, 32'h7FFF_FFFF, 1'b0}, // R6
    {3'd4, 32'h7FFF_FFF0, 32'h0000_0000, 16'h0010, 32'h8000_0000, 1'b0}  // R6
  };

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [31:0] opnd_a, opnd_b, cur_pc;
  logic [15:0] imm16;
  logic [31:0] sum_out, fetch_target, saved_pc;
  logic        wr_en, redirect;

  int checks;
  int fails;
  logic [31:0] exp_epc;

  addsub_trap_unit #(.HANDLER_ADDR(HANDLER)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .imm16(imm16), .cur_pc(cur_pc),
    .sum_out(sum_out), .wr_en(wr_en), .redirect(redirect),
    .fetch_target(fetch_target), .saved_pc(saved_pc)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] im, input logic [31:0] pc);
    @(negedge clk);
    op_valid = v; op_code = op; opnd_a = a; opnd_b = b; imm16 = im; cur_pc = pc;
    #1;
  endtask

  task automatic settle_edge();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #150000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    rst_n = 1'b0; op_valid = 1'b0; op_code = 3'd0;
    opnd_a = '0; opnd_b = '0; imm16 = '0; cur_pc = 32'h0000_1000;
    #12;
    check("R10 reset epc", saved_pc, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    exp_epc = 32'h0;

    for (int i = 0; i < NV; i++) begin
      logic [2:0]  vop;
      logic [31:0] va, vb, vs, pc;
      logic [15:0] vi;
      logic        vt;
      {vop, va, vb, vi, vs, vt} = VEC[i];
      pc = 32'h0000_2000 + 32'(i * 4);
      drive(1'b1, vop, va, vb, vi, pc);
      check("R1/R2/R3 sum", sum_out, vs);
      check("R4/R5/R6/R7 redirect", {31'b0, redirect}, {31'b0, vt});
      check("R6/R7 wr_en", {31'b0, wr_en}, {31'b0, !vt});
      check("R7/R8 target", fetch_target, vt ? HANDLER : pc + 32'd4);
      if (vt) exp_epc = pc;
      settle_edge();
      check("R9 saved_pc", saved_pc, exp_epc);
    end

    // R11: idle cycle with overflowing operands
    drive(1'b0, 3'd0, 32'h7FFF_FFFF, 32'h1, 16'h0, 32'h0000_3000);
    check("R11 idle wr_en", {31'b0, wr_en}, 32'h0);
    check("R11 idle redirect", {31'b0, redirect}, 32'h0);
    settle_edge();
    check("R11 idle epc", saved_pc, exp_epc);

    // R12: unused opcodes
    for (int k = 6; k < 8; k++) begin
      drive(1'b1, 3'(k), 32'h7FFF_FFFF, 32'h1, 16'h0, 32'h0000_3100);
      check("R12 unused wr_en", {31'b0, wr_en}, 32'h0);
      check("R12 unused redirect", {31'b0, redirect}, 32'h0);
      settle_edge();
      check("R12 unused epc", saved_pc, exp_epc);
    end

    // R9: trap at a new PC then hold
    drive(1'b1, 3'd2, 32'h8000_0000, 32'h1, 16'h0, 32'h0000_4444);
    settle_edge();
    check("R9 second trap epc", saved_pc, 32'h0000_4444);
    drive(1'b1, 3'd0, 32'h1, 32'h1, 16'h0, 32'h0000_5000);
    settle_edge();
    check("R9 hold epc", saved_pc, 32'h0000_4444);

    // R10: reset clears the saved PC
    @(negedge clk); rst_n = 1'b0; op_valid = 1'b0;
    #1;
    check("R10 reset clears epc", saved_pc, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule